// File: doc/BRIEF.md
# Erase/Program/Verify Operation Sequencer

This block runs one job against a target memory: a bulk erase, a compare-only verify, or a full program pass. A two-bit selector chooses the job. A one-cycle execute strobe launches it. The sequencer issues abstract sub-operation requests to a protocol engine that lives outside the block, and each request gets a single reply carrying an ok flag and a checksum value. The low-level target protocol, the memory model and the display decoding all sit outside this block.

A program job is a fixed chain of steps. The serial-number step runs only when serialisation is enabled at launch. The protection step runs only after the automatic verify has passed. The chain stops at the first failing step.

When a job ends, the sequencer drives the operator indication:
- The status LED turns green or red.
- The beeper plays three short beeps on success or one long beep on failure.
- On success the display shows the checksum, and it keeps showing it.
- On failure the display shows a negative error code for a fixed hold time and then goes blank.
- While a job runs, an activity LED blinks.

All beep, blink and hold durations are counted in ticks of a parameterised prescaler.

Top module: `opseq_top`

## Requirements
- R1: After reset, the block is in the idle state:
  - `busy`, `op_valid`, `led_green`, `led_red`, `led_act`, `beep` and `disp_show` are low.
  - `op_serial` is zero.
- R2: `mode_sel` selects the job: 0 = erase, 1 = verify, 2 = program. A single-cycle `exec` while idle launches the selected job. When `mode_sel` is 3, `exec` starts nothing.
- R3: Program issues its steps in this order:
  - erase (code 0)
  - image (code 1)
  - serial (code 2), only if `serial_en` was high at launch
  - option bits (code 3)
  - verify (code 4)
  - protection (code 5)

  Protection is issued only after verify replies ok.
- R4: An erase job issues only the erase step. A verify job issues only the verify step.
- R5: A reply with `rsp_ok` low ends the job at once, and no further step is issued. The error code is the failing step's code plus one. It is shown on `disp_val` as its negative, in DW-bit two's complement.
- R6: `op_serial` increases by exactly one after each successful program job that had serialisation enabled. It is unchanged after any other job.
- R7: Request handshake:
  - `op_valid` stays high with a stable `op_code` until a cycle in which `rsp_valid` is high.
  - Exactly one reply is consumed per request.
  - The block never stalls `rsp_valid`.
- R8: On success:
  - `led_green` rises and `led_red` stays low.
  - `disp_show` is high and `disp_val` holds the checksum from the last ok reply to an erase or verify step.
  - `beep` gives three pulses of SHORT_TICKS×TICK_DIV cycles each, separated by gaps of the same length.
- R9: On failure:
  - `led_red` rises.
  - `beep` gives one pulse of LONG_TICKS×TICK_DIV cycles.
  - The error code is shown for HOLD_TICKS×TICK_DIV cycles, after which `disp_show` falls.
- R10: `led_act` toggles every BLINK_TICKS×TICK_DIV cycles while `busy` is high, and is low while idle.
- R11: An `exec` that arrives while a job is running has no effect on that job's steps, and does not start a second job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Job select: 0 erase, 1 verify, 2 program, 3 none |
| exec | input | 1 | Launch strobe |
| serial_en | input | 1 | Enables the serial-number step in program jobs |
| op_valid | output | 1 | Sub-operation request valid |
| op_code | output | 3 | Step code: 0 erase, 1 image, 2 serial, 3 options, 4 verify, 5 protect |
| op_serial | output | SW | Serial number that the serial step should write |
| rsp_valid | input | 1 | Reply strobe for the current request |
| rsp_ok | input | 1 | Reply status, 1 = step succeeded |
| rsp_sum | input | DW | Checksum carried with the reply |
| busy | output | 1 | A job is running |
| led_green | output | 1 | Status LED green (last job passed) |
| led_red | output | 1 | Status LED red (last job failed) |
| led_act | output | 1 | Blinking activity LED |
| beep | output | 1 | Beeper drive |
| disp_show | output | 1 | Display content valid |
| disp_val | output | DW | Checksum, or the negated error code |

## Verification
The hardest situation to reach from the ports is protection gating: a verify that fails inside a program chain must stop the chain before the protection request. The bench reaches it with a responder model that refuses one chosen step code, set to the verify code. It then checks the logged request sequence, the error value, the red LED, and the beeper and hold lengths. Busy-time `exec` pulses with a different mode are injected in the middle of a slow program chain. The logged sequence must stay the full chain.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
  typedef enum logic [2:0] {
    OP_ERASE  = 3'd0,
    OP_IMAGE  = 3'd1,
    OP_SERIAL = 3'd2,
    OP_OPTS   = 3'd3,
    OP_VERIFY = 3'd4,
    OP_PROT   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    MODE_ERASE   = 2'd0,
    MODE_VERIFY  = 2'd1,
    MODE_PROGRAM = 2'd2,
    MODE_NONE    = 2'd3
  } mode_e;

  function automatic op_e step_after(op_e cur, logic with_serial);
    case (cur)
      OP_ERASE:  step_after = OP_IMAGE;
      OP_IMAGE:  step_after = with_serial ? OP_SERIAL : OP_OPTS;
      OP_SERIAL: step_after = OP_OPTS;
      OP_OPTS:   step_after = OP_VERIFY;
      default:   step_after = OP_PROT;
    endcase
  endfunction
endpackage

// File: rtl/opseq_prescale.sv
module opseq_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt;

  assign tick = (cnt == W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
  import opseq_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_i,
  input  logic [1:0]    mode_i,
  input  logic          serial_en_i,
  output logic          op_valid_o,
  output logic [2:0]    op_code_o,
  input  logic          rsp_valid_i,
  input  logic          rsp_ok_i,
  input  logic [DW-1:0] rsp_sum_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          green_o,
  output logic          red_o,
  output logic [2:0]    err_o,
  output logic [DW-1:0] sum_o,
  output logic [SW-1:0] serial_o
);
  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e        state;
  op_e           cur_op;
  mode_e         run_mode;
  logic          sen_q;
  logic          last_step;
  logic          launch;

  assign launch     = (state == S_IDLE) && exec_i && (mode_e'(mode_i) != MODE_NONE);
  assign busy_o     = (state == S_RUN);
  assign op_valid_o = (state == S_RUN);
  assign op_code_o  = cur_op;

  always_comb begin
    case (run_mode)
      MODE_ERASE:  last_step = (cur_op == OP_ERASE);
      MODE_VERIFY: last_step = (cur_op == OP_VERIFY);
      default:     last_step = (cur_op == OP_PROT);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_op   <= OP_ERASE;
      run_mode <= MODE_ERASE;
      sen_q    <= 1'b0;
      done_o   <= 1'b0;
      pass_o   <= 1'b0;
      green_o  <= 1'b0;
      red_o    <= 1'b0;
      err_o    <= '0;
      sum_o    <= '0;
      serial_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (launch) begin
            state    <= S_RUN;
            run_mode <= mode_e'(mode_i);
            sen_q    <= serial_en_i;
            cur_op   <= (mode_e'(mode_i) == MODE_VERIFY) ? OP_VERIFY : OP_ERASE;
            green_o  <= 1'b0;
            red_o    <= 1'b0;
            err_o    <= '0;
          end
        end
        default: begin
          if (rsp_valid_i) begin
            if (!rsp_ok_i) begin
              state  <= S_IDLE;
              done_o <= 1'b1;
              pass_o <= 1'b0;
              red_o  <= 1'b1;
              err_o  <= 3'(cur_op) + 3'd1;
            end else begin
              if (cur_op == OP_ERASE || cur_op == OP_VERIFY) sum_o <= rsp_sum_i;
              if (last_step) begin
                state   <= S_IDLE;
                done_o  <= 1'b1;
                pass_o  <= 1'b1;
                green_o <= 1'b1;
                if (run_mode == MODE_PROGRAM && sen_q) serial_o <= serial_o + 1'b1;
              end else begin
                cur_op <= step_after(cur_op, sen_q);
              end
            end
          end
        end
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_o && !rsp_valid_i |=> op_valid_o && $stable(op_code_o)); // R7
  AST_PROT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid_o && cur_op == OP_PROT) |-> $past(rsp_valid_i && rsp_ok_i && cur_op == OP_VERIFY)); // R3
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(run_mode)); // R11
  AST_LED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(green_o && red_o)); // R8
  AST_SERIAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    serial_o != $past(serial_o) |-> serial_o == $past(serial_o) + 1'b1 && $past(rsp_ok_i)); // R6
endmodule

// File: rtl/opseq_annun.sv
module opseq_annun #(
  parameter int TICK_DIV    = 4,
  parameter int SHORT_TICKS = 3,
  parameter int LONG_TICKS  = 10,
  parameter int HOLD_TICKS  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic pass_i,
  output logic beep_o,
  output logic show_err_o
);
  localparam int LMAX = (SHORT_TICKS > LONG_TICKS) ? SHORT_TICKS : LONG_TICKS;
  localparam int CW   = $clog2(LMAX + 1);
  localparam int HW   = $clog2(HOLD_TICKS + 1);

  logic          tick;
  logic          active;
  logic          pass_q;
  logic [2:0]    phase;
  logic [CW-1:0] tcnt;
  logic [CW-1:0] lim;
  logic          hold;
  logic [HW-1:0] hcnt;

  opseq_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .tick(tick)
  );

  assign lim        = pass_q ? CW'(SHORT_TICKS - 1) : CW'(LONG_TICKS - 1);
  assign beep_o     = active && (pass_q ? !phase[0] : 1'b1);
  assign show_err_o = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pass_q <= 1'b0;
      phase  <= '0;
      tcnt   <= '0;
      hold   <= 1'b0;
      hcnt   <= '0;
    end else if (start_i) begin
      active <= 1'b1;
      pass_q <= pass_i;
      phase  <= '0;
      tcnt   <= '0;
      hold   <= !pass_i;
      hcnt   <= '0;
    end else begin
      if (active && tick) begin
        if (tcnt == lim) begin
          tcnt <= '0;
          if (!pass_q || phase == 3'd4) active <= 1'b0;
          else                          phase  <= phase + 3'd1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
      if (hold && tick) begin
        if (hcnt == HW'(HOLD_TICKS - 1)) begin
          hold <= 1'b0;
          hcnt <= '0;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  AST_SHORT_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
    active && pass_q |-> phase <= 3'd4); // R8
  AST_HOLD_ONLY_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !pass_q); // R9
  AST_LONG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    active && !pass_q |-> phase == 3'd0); // R9
endmodule

// File: rtl/opseq_blink.sv
module opseq_blink #(
  parameter int TICK_DIV    = 4,
  parameter int BLINK_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic led_o
);
  localparam int BW = $clog2(BLINK_TICKS + 1);

  logic          tick;
  logic          phase_q;
  logic [BW-1:0] cnt;

  opseq_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(!busy_i), .tick(tick)
  );

  assign led_o = busy_i && phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b1;
      cnt     <= '0;
    end else if (!busy_i) begin
      phase_q <= 1'b1;
      cnt     <= '0;
    end else if (tick) begin
      if (cnt == BW'(BLINK_TICKS - 1)) begin
        cnt     <= '0;
        phase_q <= !phase_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> !$past(led_o)); // R10
endmodule

// File: rtl/opseq_top.sv
module opseq_top #(
  parameter int DW          = 16,
  parameter int SW          = 16,
  parameter int TICK_DIV    = 100000,
  parameter int SHORT_TICKS = 100,
  parameter int LONG_TICKS  = 600,
  parameter int HOLD_TICKS  = 2000,
  parameter int BLINK_TICKS = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          exec,
  input  logic          serial_en,
  output logic          op_valid,
  output logic [2:0]    op_code,
  output logic [SW-1:0] op_serial,
  input  logic          rsp_valid,
  input  logic          rsp_ok,
  input  logic [DW-1:0] rsp_sum,
  output logic          busy,
  output logic          led_green,
  output logic          led_red,
  output logic          led_act,
  output logic          beep,
  output logic          disp_show,
  output logic [DW-1:0] disp_val
);
  logic          done;
  logic          pass;
  logic [2:0]    err;
  logic [DW-1:0] sum;
  logic          show_err;

  opseq_ctrl #(.DW(DW), .SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .exec_i(exec), .mode_i(mode_sel),
    .serial_en_i(serial_en), .op_valid_o(op_valid), .op_code_o(op_code),
    .rsp_valid_i(rsp_valid), .rsp_ok_i(rsp_ok), .rsp_sum_i(rsp_sum),
    .busy_o(busy), .done_o(done), .pass_o(pass), .green_o(led_green),
    .red_o(led_red), .err_o(err), .sum_o(sum), .serial_o(op_serial)
  );

  opseq_annun #(
    .TICK_DIV(TICK_DIV), .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS(LONG_TICKS), .HOLD_TICKS(HOLD_TICKS)
  ) u_annun (
    .clk(clk), .rst_n(rst_n), .start_i(done), .pass_i(pass),
    .beep_o(beep), .show_err_o(show_err)
  );

  opseq_blink #(.TICK_DIV(TICK_DIV), .BLINK_TICKS(BLINK_TICKS)) u_blink (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .led_o(led_act)
  );

  assign disp_show = show_err || led_green;
  assign disp_val  = show_err ? (DW'(0) - DW'(err)) : sum;

  AST_ERR_WITH_RED: assert property (@(posedge clk) disable iff (!rst_n)
    show_err |-> led_red); // R9
endmodule

// File: tb/opseq_top_tb.sv
module opseq_top_tb;
  localparam int DW = 16;
  localparam int SW = 16;
  localparam int DIV = 4;
  localparam int SHORT = 3;
  localparam int LONG = 10;
  localparam int HOLD = 20;
  localparam int BLINK = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] mode_sel = 0;
  logic exec = 0;
  logic serial_en = 0;
  logic op_valid;
  logic [2:0] op_code;
  logic [SW-1:0] op_serial;
  logic rsp_valid = 0;
  logic rsp_ok = 0;
  logic [DW-1:0] rsp_sum = 0;
  logic busy, led_green, led_red, led_act, beep, disp_show;
  logic [DW-1:0] disp_val;

  always #2 clk = ~clk;

  opseq_top #(.DW(DW), .SW(SW), .TICK_DIV(DIV), .SHORT_TICKS(SHORT),
    .LONG_TICKS(LONG), .HOLD_TICKS(HOLD), .BLINK_TICKS(BLINK)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .exec(exec),
    .serial_en(serial_en), .op_valid(op_valid), .op_code(op_code),
    .op_serial(op_serial), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_sum(rsp_sum), .busy(busy), .led_green(led_green), .led_red(led_red),
    .led_act(led_act), .beep(beep), .disp_show(disp_show), .disp_val(disp_val)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // responder model
  int fail_code = -1;
  int rsp_delay = 2;
  int logged [0:15];
  int n_logged = 0;
  int hold_err = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (op_valid) begin
        automatic logic [2:0] code = op_code;
        if (n_logged < 16) logged[n_logged] = int'(code);
        n_logged++;
        for (int i = 0; i < rsp_delay; i++) begin
          @(negedge clk);
          if (!op_valid || op_code != code) hold_err++;
        end
        rsp_valid = 1;
        rsp_ok = (int'(code) != fail_code);
        rsp_sum = DW'(16'h00A5 + code);
        @(negedge clk);
        rsp_valid = 0;
        rsp_ok = 0;
      end
    end
  end

  // output monitor
  int beep_edges = 0, beep_hi = 0, beep_run = 0, beep_max = 0;
  int err_cycles = 0, act_edges = 0, act_idle = 0;
  logic beep_prev = 0, act_prev = 0;
  logic [DW-1:0] err_seen = 0;

  always @(negedge clk) begin
    cyc++;
    if (beep && !beep_prev) beep_edges++;
    if (beep) begin beep_hi++; beep_run++; if (beep_run > beep_max) beep_max = beep_run; end
    else beep_run = 0;
    if (disp_show && led_red) begin err_cycles++; err_seen = disp_val; end
    if (led_act && !act_prev) act_edges++;
    if (led_act && !busy) act_idle++;
    beep_prev = beep;
    act_prev = led_act;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    beep_edges = 0; beep_hi = 0; beep_max = 0; err_cycles = 0;
    act_edges = 0; act_idle = 0; n_logged = 0; hold_err = 0;
  endtask

  task automatic launch(input logic [1:0] m, input logic sen);
    @(negedge clk);
    mode_sel = m; serial_en = sen; exec = 1;
    @(negedge clk);
    exec = 0;
  endtask

  task automatic finish_job();
    while (busy) @(negedge clk);
    repeat (100) @(negedge clk);
  endtask

  task automatic chk_seq(input string req, input int exp [0:7], input int n);
    chk(n_logged == n, req, n_logged, n);
    for (int i = 0; i < n && i < n_logged; i++)
      chk(logged[i] == exp[i], req, logged[i], exp[i]);
  endtask

  task automatic chk_pass(input string req, input int sum);
    chk(led_green && !led_red, req, led_green, 1);
    chk(disp_show && disp_val == DW'(sum), req, disp_val, sum);
    chk(beep_edges == 3, req, beep_edges, 3);
    chk(beep_hi == 3 * SHORT * DIV && beep_max == SHORT * DIV, req, beep_hi, 3 * SHORT * DIV);
  endtask

  task automatic chk_fail(input string req, input int code);
    chk(led_red && !led_green, req, led_red, 1);
    chk(beep_edges == 1 && beep_hi == LONG * DIV, req, beep_hi, LONG * DIV);
    chk(err_cycles == HOLD * DIV, req, err_cycles, HOLD * DIV);
    chk(err_seen == DW'(0) - DW'(code), req, err_seen, (1 << DW) - code);
    chk(!disp_show, req, disp_show, 0);
  endtask

  task automatic t_reset();
    // R1
    chk(!busy && !op_valid && !led_green && !led_red && !led_act, "R1", busy, 0);
    chk(!beep && !disp_show && op_serial == 0, "R1", op_serial, 0);
  endtask

  task automatic t_bad_mode();
    // R2: selector value 3 starts nothing
    clr_mon();
    launch(2'd3, 1'b0);
    repeat (10) @(negedge clk);
    chk(!busy && !op_valid && n_logged == 0, "R2", n_logged, 0);
  endtask

  task automatic t_erase_mode();
    int e [0:7] = '{0, 0, 0, 0, 0, 0, 0, 0};
    clr_mon(); fail_code = -1; rsp_delay = 2;
    launch(2'd0, 1'b1);
    finish_job();
    chk_seq("R4", e, 1);
    chk_pass("R8", 16'h00A5);
    chk(op_serial == 0, "R6", op_serial, 0);
    chk(act_idle == 0, "R10", act_idle, 0);
  endtask

  task automatic t_verify_mode();
    int e [0:7] = '{4, 0, 0, 0, 0, 0, 0, 0};
    clr_mon(); fail_code = -1; rsp_delay = 1;
    launch(2'd1, 1'b0);
    finish_job();
    chk_seq("R4", e, 1);
    chk_pass("R8", 16'h00A9);
  endtask

  task automatic t_program_serial();
    int e [0:7] = '{0, 1, 2, 3, 4, 5, 0, 0};
    clr_mon(); fail_code = -1; rsp_delay = 6;
    launch(2'd2, 1'b1);
    finish_job();
    chk_seq("R3", e, 6);
    chk(hold_err == 0, "R7", hold_err, 0);
    chk_pass("R8", 16'h00A9);
    chk(op_serial == 1, "R6", op_serial, 1);
    chk(act_edges >= 3, "R10", act_edges, 3);
    chk(act_idle == 0 && !led_act, "R10", act_idle, 0);
  endtask

  task automatic t_program_noserial();
    int e [0:7] = '{0, 1, 3, 4, 5, 0, 0, 0};
    clr_mon(); fail_code = -1; rsp_delay = 2;
    launch(2'd2, 1'b0);
    finish_job();
    chk_seq("R3", e, 5);
    chk(op_serial == 1, "R6", op_serial, 1);
  endtask

  task automatic t_verify_fail();
    int e [0:7] = '{0, 1, 2, 3, 4, 0, 0, 0};
    clr_mon(); fail_code = 4; rsp_delay = 2;
    launch(2'd2, 1'b1);
    finish_job();
    chk_seq("R3", e, 5);
    chk_fail("R9", 5);
    chk(op_serial == 1, "R6", op_serial, 1);
  endtask

  task automatic t_image_fail();
    int e [0:7] = '{0, 1, 0, 0, 0, 0, 0, 0};
    clr_mon(); fail_code = 1; rsp_delay = 1;
    launch(2'd2, 1'b1);
    finish_job();
    chk_seq("R5", e, 2);
    chk_fail("R5", 2);
    chk(op_serial == 1, "R6", op_serial, 1);
  endtask

  task automatic t_busy_ignore();
    int e [0:7] = '{0, 1, 2, 3, 4, 5, 0, 0};
    clr_mon(); fail_code = -1; rsp_delay = 5;
    launch(2'd2, 1'b1);
    repeat (8) @(negedge clk);
    launch(2'd0, 1'b0);
    repeat (12) @(negedge clk);
    launch(2'd1, 1'b0);
    finish_job();
    chk_seq("R11", e, 6);
    chk(!busy && op_serial == 2, "R11", op_serial, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_bad_mode();
    t_erase_mode();
    t_verify_mode();
    t_program_serial();
    t_program_noserial();
    t_verify_fail();
    t_image_fail();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule